// File: doc/BRIEF.md
# Serial Configuration Bitstream Reader

This block is the read side of a serial configuration memory. It holds a small array of stored words and sends them out one bit per clock on a single data line. Each word goes out least significant bit first, and words go out in ascending address order. A bit index and a word address record the read position. Both advance on every qualifying rising edge of the configuration clock. The serial output has a separate drive-enable, so a tri-state pad can be wired to the pair.

Two pins control the read. The first is a load-restart pin (`cfg_rst`, active high). While it is high the output is not driven, and a clock edge returns the position to the first stored bit. While it is low the output is enabled. The second is an active-low chip select (`ce_n`). When it is high the output goes quiet and the position freezes. If `cfg_rst` stays low, the position survives from one load to the next. Several images can therefore be stored back to back and read out in turn.

When the last bit of the last word has gone out, the position wraps to the first bit and an end flag is raised. The array is filled through a simple word-write port, which is accepted only while `cfg_rst` is high.

Top module: `prom_serial_seq`

## Requirements
- R1: While `rst_n` is low, `sdata_en_o` and `end_o` are 0. After `rst_n` is released, the first bit presented is bit 0 of word 0.
- R2: `sdata_en_o` is 1 exactly when `ce_n` is 0, `cfg_rst` is 0 and reset has been released. Whenever `sdata_en_o` is 0, `sdata_o` is 0.
- R3: Each rising edge with `ce_n`=0 and `cfg_rst`=0 moves the output to the next bit. Bit index WIDTH-1 of a word is followed by bit 0 of the next address.
- R4: A rising edge with `cfg_rst`=1 returns the position to word 0, bit 0, and clears `end_o`.
- R5: While `ce_n`=1 and `cfg_rst`=0, clock edges change neither the position nor `end_o`.
- R6: If `cfg_rst` is held low, a pause between loads (`ce_n` high) keeps the position. The next load continues with the bit that followed the last bit sent.
- R7: The edge that leaves the last bit of word DEPTH-1 moves the position to word 0, bit 0, and sets `end_o`. `end_o` then stays 1 until an R4 clear.
- R8: A write stores `wr_data` at `wr_addr` on an edge where both `wr_en` and `cfg_rst` are 1. When `cfg_rst` is 0, `wr_en` has no effect on the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_rst | input | 1 | Load restart / output-enable pin, high = restart and no drive |
| ce_n | input | 1 | Active-low chip select |
| wr_en | input | 1 | Fill-port write strobe |
| wr_addr | input | $clog2(DEPTH) | Fill-port word address |
| wr_data | input | WIDTH | Fill-port word data |
| sdata_o | output | 1 | Serial data bit (0 when not driven) |
| sdata_en_o | output | 1 | Drive enable for the serial pad |
| end_o | output | 1 | Set when the read position has wrapped past the last word |

## Verification
The serial bit and the end flag are decoded from registered state. They show the effect of a qualifying edge right after that edge, with no extra pipeline stage. The drive enable follows `ce_n` and `cfg_rst` in the same cycle, and fill writes land on the edge that samples them. The bench moves its inputs one time unit after a rising edge and compares outputs two units after it. It advances its own bit-position model exactly at each edge, so every comparison lands in the cycle where that edge's result is due.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;

  // Position update chosen each cycle by the counter next-state logic.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_BIT   = 2'd1,
    OP_WORD  = 2'd2,
    OP_CLEAR = 2'd3
  } pos_op_e;

endpackage

// File: rtl/prom_rst_sync.sv
module prom_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/prom_bit_store.sv
module prom_bit_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic [BW-1:0]    rd_bit,
  output logic             rd_data
);

  logic [WIDTH-1:0] words [DEPTH];
  logic [WIDTH-1:0] sel_word;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [WIDTH-1:0] word_q;
    logic             hit;

    assign hit = wr_en && (wr_addr == AW'(w));

    // storage cells carry no reset
    always_ff @(posedge clk) begin
      if (hit) word_q <= wr_data;
    end

    assign words[w] = word_q;
  end

  always_comb begin
    sel_word = words[rd_addr];
    rd_data  = sel_word[rd_bit];
  end

endmodule

// File: rtl/prom_pos_ctr.sv
module prom_pos_ctr
  import prom_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] bitpos,
  output logic          end_flag
);

  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
  localparam logic [BW-1:0] LAST_B = BW'(WIDTH - 1);

  pos_op_e       op;
  logic [AW-1:0] addr_q, addr_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          end_q, end_d;

  // next-state
  always_comb begin
    if (clr)                      op = OP_CLEAR;
    else if (adv && bit_q == LAST_B) op = OP_WORD;
    else if (adv)                 op = OP_BIT;
    else                          op = OP_HOLD;

    addr_d = addr_q;
    bit_d  = bit_q;
    end_d  = end_q;
    unique case (op)
      OP_CLEAR: begin
        addr_d = '0;
        bit_d  = '0;
        end_d  = 1'b0;
      end
      OP_BIT: begin
        bit_d = bit_q + 1'b1;
      end
      OP_WORD: begin
        bit_d = '0;
        if (addr_q == LAST_A) begin
          addr_d = '0;
          end_d  = 1'b1;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bit_q  <= '0;
      end_q  <= 1'b0;
    end else if (op != OP_HOLD) begin
      addr_q <= addr_d;
      bit_q  <= bit_d;
      end_q  <= end_d;
    end
  end

  assign addr     = addr_q;
  assign bitpos   = bit_q;
  assign end_flag = end_q;

endmodule

// File: rtl/prom_serial_seq.sv
module prom_serial_seq #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rst,
  input  logic             ce_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic             sdata_o,
  output logic             sdata_en_o,
  output logic             end_o
);

  logic          rst_q_n;
  logic          live;
  logic          fill_we;
  logic          rd_data;
  logic [AW-1:0] rd_addr;
  logic [BW-1:0] rd_bit;

  prom_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  // an edge qualifies only when selected, not restarting and out of reset
  assign live    = rst_q_n && !ce_n && !cfg_rst;
  assign fill_we = wr_en && cfg_rst;

  prom_pos_ctr #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_pos (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (cfg_rst),
    .adv      (live),
    .addr     (rd_addr),
    .bitpos   (rd_bit),
    .end_flag (end_o)
  );

  prom_bit_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .wr_en   (fill_we),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_bit  (rd_bit),
    .rd_data (rd_data)
  );

  assign sdata_en_o = live;
  assign sdata_o    = live & rd_data;

endmodule

// File: rtl/prom_serial_seq_chk.sv
module prom_serial_seq_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          cfg_rst,
  input logic          ce_n,
  input logic [AW-1:0] rd_addr,
  input logic [BW-1:0] rd_bit,
  input logic          end_o,
  input logic          sdata_en_o,
  input logic          sdata_o
);

  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
  localparam logic [BW-1:0] LAST_B = BW'(WIDTH - 1);

  // R1: quiet and flag low while held in reset
  a_r1_idle: assert property (@(posedge clk)
    !rst_q_n |-> (!sdata_en_o && !end_o));

  // R2: no drive and no data when deselected or restarting
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ce_n || cfg_rst) |-> (!sdata_en_o && !sdata_o));

  // R3: a qualifying edge inside a word steps the bit only
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ce_n && !cfg_rst && rd_bit != LAST_B) |=>
      (rd_bit == BW'($past(rd_bit) + 1'b1) && $stable(rd_addr)));

  // R4: restart returns to the first bit and clears the flag
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_rst |=> (rd_addr == '0 && rd_bit == '0 && !end_o));

  // R5: deselected edges leave the position alone
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ce_n && !cfg_rst) |=>
      ($stable(rd_addr) && $stable(rd_bit) && $stable(end_o)));

  // R7: leaving the final bit wraps and raises the flag
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ce_n && !cfg_rst && rd_bit == LAST_B && rd_addr == LAST_A) |=>
      (rd_addr == '0 && rd_bit == '0 && end_o));

endmodule

bind prom_serial_seq prom_serial_seq_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .cfg_rst    (cfg_rst),
  .ce_n       (ce_n),
  .rd_addr    (rd_addr),
  .rd_bit     (rd_bit),
  .end_o      (end_o),
  .sdata_en_o (sdata_en_o),
  .sdata_o    (sdata_o)
);

// File: tb/prom_serial_seq_test.sv
module prom_serial_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int TOTAL = DEPTH * WIDTH;
  localparam int AW = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n, cfg_rst, ce_n, wr_en;
  logic [AW-1:0]    wr_addr;
  logic [WIDTH-1:0] wr_data;
  logic             sdata_o, sdata_en_o, end_o;

  logic [WIDTH-1:0] img [DEPTH];
  int pos;
  bit end_m;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_serial_seq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_rst(cfg_rst), .ce_n(ce_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdata_o(sdata_o), .sdata_en_o(sdata_en_o), .end_o(end_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (pos %0d)", req, what, act, exp, pos);
    end
  endtask

  // advance one edge, updating the bit-position model from the inputs seen at that edge
  task automatic tick();
    @(posedge clk);
    if (cfg_rst) begin
      pos = 0;
      end_m = 0;
    end else if (rst_n && !ce_n) begin
      if (pos == TOTAL - 1) begin
        pos = 0;
        end_m = 1;
      end else begin
        pos++;
      end
    end
    #1;
  endtask

  task automatic look(input string req);
    bit en;
    #1;
    en = !ce_n && !cfg_rst;
    chk(req, "drive", int'(sdata_en_o), int'(en));
    chk(req, "bit", int'(sdata_o), en ? int'(img[pos / WIDTH][pos % WIDTH]) : 0);
    chk(req, "end", int'(end_o), int'(end_m));
  endtask

  task automatic t_reset();
    rst_n = 0; cfg_rst = 0; ce_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    pos = 0; end_m = 0;
    tick(); tick(); #1;
    chk("R1", "drive in reset", int'(sdata_en_o), 0);
    chk("R1", "end in reset", int'(end_o), 0);
    cfg_rst = 1; ce_n = 1;
    rst_n = 1;
    tick(); tick(); tick();
    look("R1");
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      img[i] = WIDTH'((i * 29 + 7) ^ 8'hC3);
      wr_addr = AW'(i); wr_data = img[i]; wr_en = 1;
      tick();
    end
    wr_en = 0;
  endtask

  task automatic t_stream();
    cfg_rst = 0; ce_n = 0;
    look("R1");
    repeat (20) begin
      tick();
      look("R3");
    end
  endtask

  task automatic t_suspend();
    ce_n = 1;
    repeat (6) begin
      tick();
      look("R5");
    end
    #1;
    chk("R2", "deselected drive", int'(sdata_en_o), 0);
    ce_n = 0;
    look("R5");
    tick();
    look("R5");
  endtask

  task automatic t_retain_wrap();
    while (pos != 4 * WIDTH - 1) begin
      tick();
      look("R3");
    end
    // pause between loads; a write attempt with cfg_rst low must be dropped
    ce_n = 1;
    wr_addr = AW'(2); wr_data = ~img[2]; wr_en = 1;
    tick();
    wr_en = 0;
    tick(); tick(); tick();
    look("R6");
    ce_n = 0;
    look("R6");
    while (pos != TOTAL - 1) begin
      tick();
      look("R6");
    end
    chk("R7", "end before wrap", int'(end_o), 0);
    tick();
    look("R7");
    chk("R7", "end after wrap", int'(end_o), 1);
    repeat (3 * WIDTH) begin
      tick();
      look("R8");
    end
  endtask

  task automatic t_clear();
    repeat (5) tick();
    cfg_rst = 1;
    tick();
    look("R4");
    #1;
    chk("R2", "restart drive", int'(sdata_en_o), 0);
    cfg_rst = 0;
    look("R4");
    chk("R4", "end cleared", int'(end_o), 0);
    repeat (10) begin
      tick();
      look("R4");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_stream();
    t_suspend();
    t_retain_wrap();
    t_clear();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule